// File: doc/BRIEF.md
# Byte Register Bridge

This block lets a 32-bit host reach an 8-bit register space in a slower subsystem by indirection. The host first programs a control word that names the subsystem byte address, the transfer direction and the byte lanes. It then moves data through a lower data register. A busy bit in the control word is set while a subsystem transfer is in flight, and the host polls it to learn when the transfer has finished.

A subsystem write is launched by the host's write to the lower data register, provided that the stored direction is write. A subsystem read is launched by the control-word write itself when its direction bit requests a read. The byte returned by the subsystem is zero-extended into the lower data register. On the subsystem side, a level request is held with a stable address and stable write data until a one-cycle acknowledge arrives after a latency the subsystem chooses.

The bridge also holds an interrupt enable register and a flag register. One flag records a rising edge on the subsystem interrupt line. The other flag records the completion of a transfer. The host interrupt output is the OR of the enabled flags.

Top module: `byte_reg_bridge`

## Requirements
- R1: After reset, busy, subReq and irqOut are 0, and the control (0x04), lower data (0x08), upper data (0x0C), enable (0x10) and flag (0x14) registers all read 0.
- R2: Offset 0x00 always reads the ID_VALUE parameter (default 0x42520001), and host writes to it have no effect.
- R3: The control word at 0x04 holds busy in bit 31, size in bit 25, direction in bit 24 (1 = read), upper lane enables in bits 23:20, lower lane enables in bits 19:16 and the subsystem address in bits 7:0. A control write with bit 24 = 1 and bit 16 = 1 launches a read and sets busy. When the acknowledge arrives, busy clears and the lower data register holds the returned byte, zero-extended.
- R4: A control write with direction 0 launches nothing. A later write to lower data (0x08) launches a subsystem write of data bits 7:0 to the stored address, with subWr = 1.
- R5: subReq stays high, and subAddr, subWr and subWdata stay stable, until subAck is seen. subReq is low in the cycle after the acknowledge.
- R6: While busy, host writes to the control and lower data registers are ignored and launch nothing.
- R7: When lower lane enable bit 16 is 0, neither a read control write nor a lower data write launches a transfer.
- R8: The upper data register (0x0C) stores and reads back a full 32-bit word and never launches a transfer.
- R9: A rising edge of subIrq sets flag bit 1. A level held high does not set it again once it has been cleared.
- R10: Each completed transfer sets flag bit 0.
- R11: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R12: irqOut equals the OR over both bits of flag AND enable, where the enable register is at 0x10 and bit 1 is the subsystem source and bit 0 is the completion source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostEn | input | 1 | Host access strobe |
| hostWe | input | 1 | Host write when high |
| hostAddr | input | HOST_AW | Host byte offset |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data for hostAddr |
| subReq | output | 1 | Subsystem request, held until acknowledge |
| subWr | output | 1 | Subsystem direction, 1 = write |
| subAddr | output | SUB_AW | Subsystem byte address |
| subWdata | output | 8 | Subsystem write byte |
| subAck | input | 1 | One-cycle subsystem acknowledge |
| subRdata | input | 8 | Subsystem read byte, valid with subAck |
| subIrq | input | 1 | Subsystem interrupt level |
| irqOut | output | 1 | Host interrupt |

## Verification
The assertions assume that the subsystem pulses subAck for exactly one cycle, and only while subReq is high. They also assume that subRdata is valid in that same cycle. The bench's subsystem model is a byte memory. It counts request cycles up to a fixed latency, answers once, and then waits for a fresh request, so it never acknowledges an idle bridge. The host stimulus changes its inputs only on falling edges and holds the interrupt line low through reset.

// File: rtl/byte_bridge_pkg.sv
package byte_bridge_pkg;
  localparam logic [7:0] OFF_ID    = 8'h00;
  localparam logic [7:0] OFF_CTRL  = 8'h04;
  localparam logic [7:0] OFF_LDATA = 8'h08;
  localparam logic [7:0] OFF_UDATA = 8'h0C;
  localparam logic [7:0] OFF_EN    = 8'h10;
  localparam logic [7:0] OFF_FLAG  = 8'h14;

  localparam int BIT_BUSY = 31;
  localparam int BIT_SIZE = 25;
  localparam int BIT_DIR  = 24;
  localparam int LSB_BENU = 20;
  localparam int LSB_BENL = 16;

  typedef struct packed {
    logic       ctrlWr;
    logic       ldataWr;
    logic       udataWr;
    logic       enWr;
    logic [1:0] flagClr;
    logic       done;
    logic       rdCapture;
    logic       irqRise;
  } strobes_t;
endpackage

// File: rtl/byte_bridge_ctrl.sv
module byte_bridge_ctrl
  import byte_bridge_pkg::*;
#(
  parameter int HOST_AW = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostEn,
  input  logic               hostWe,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               wrDir,
  input  logic               wrLane0,
  input  logic [1:0]         wrFlagBits,
  input  logic               cfgDir,
  input  logic               cfgLane0,
  input  logic               subAck,
  input  logic               subIrq,
  output strobes_t           stb,
  output logic               busy
);
  logic isWrite;
  logic irqPrev;
  logic launch;

  assign isWrite = hostEn && hostWe;

  always_comb begin
    stb = '0;
    stb.ctrlWr    = isWrite && !busy && (hostAddr == HOST_AW'(OFF_CTRL));
    stb.ldataWr   = isWrite && !busy && (hostAddr == HOST_AW'(OFF_LDATA));
    stb.udataWr   = isWrite && (hostAddr == HOST_AW'(OFF_UDATA));
    stb.enWr      = isWrite && (hostAddr == HOST_AW'(OFF_EN));
    stb.flagClr   = (isWrite && (hostAddr == HOST_AW'(OFF_FLAG))) ? wrFlagBits : 2'b00;
    stb.done      = busy && subAck;
    stb.rdCapture = busy && subAck && cfgDir;
    stb.irqRise   = subIrq && !irqPrev;
  end

  // Read starts on control write; write starts on data write.
  assign launch = (stb.ctrlWr && wrDir && wrLane0) ||
                  (stb.ldataWr && !cfgDir && cfgLane0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      irqPrev <= 1'b0;
    end else begin
      irqPrev <= subIrq;
      if (launch)
        busy <= 1'b1;
      else if (stb.done)
        busy <= 1'b0;
    end
  end
endmodule

// File: rtl/byte_bridge_dp.sv
module byte_bridge_dp
  import byte_bridge_pkg::*;
#(
  parameter int          HOST_AW  = 5,
  parameter int          SUB_AW   = 8,
  parameter logic [31:0] ID_VALUE = 32'h4252_0001
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           stb,
  input  logic               busy,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [31:0]        hostWdata,
  input  logic [7:0]         subRdata,
  output logic [31:0]        hostRdata,
  output logic               irqOut,
  output logic               cfgDir,
  output logic               cfgLane0,
  output logic [SUB_AW-1:0]  subAddr,
  output logic [7:0]         subWdata
);
  localparam int LANES = 4;

  logic              cfgSize;
  logic [LANES-1:0]  cfgBenU;
  logic [LANES-1:0]  cfgBenL;
  logic [SUB_AW-1:0] cfgAddr;
  logic [31:0]       ldata;
  logic [31:0]       udata;
  logic [1:0]        irqEn;
  logic [1:0]        irqFlag;
  logic [31:0]       ctrlWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgSize <= 1'b0;
      cfgDir  <= 1'b0;
      cfgBenU <= '0;
      cfgBenL <= '0;
      cfgAddr <= '0;
      ldata   <= '0;
      udata   <= '0;
      irqEn   <= '0;
      irqFlag <= '0;
    end else begin
      if (stb.ctrlWr) begin
        cfgSize <= hostWdata[BIT_SIZE];
        cfgDir  <= hostWdata[BIT_DIR];
        cfgBenU <= hostWdata[LSB_BENU +: LANES];
        cfgBenL <= hostWdata[LSB_BENL +: LANES];
        cfgAddr <= hostWdata[SUB_AW-1:0];
      end
      if (stb.rdCapture)
        ldata <= {24'd0, subRdata};
      else if (stb.ldataWr)
        ldata <= hostWdata;
      if (stb.udataWr)
        udata <= hostWdata;
      if (stb.enWr)
        irqEn <= hostWdata[1:0];
      // set wins over a same-cycle clear
      irqFlag[1] <= (irqFlag[1] && !stb.flagClr[1]) || stb.irqRise;
      irqFlag[0] <= (irqFlag[0] && !stb.flagClr[0]) || stb.done;
    end
  end

  always_comb begin
    ctrlWord = '0;
    ctrlWord[BIT_BUSY] = busy;
    ctrlWord[BIT_SIZE] = cfgSize;
    ctrlWord[BIT_DIR]  = cfgDir;
    ctrlWord[LSB_BENU +: LANES] = cfgBenU;
    ctrlWord[LSB_BENL +: LANES] = cfgBenL;
    ctrlWord[SUB_AW-1:0] = cfgAddr;
  end

  always_comb begin
    case (hostAddr)
      HOST_AW'(OFF_ID):    hostRdata = ID_VALUE;
      HOST_AW'(OFF_CTRL):  hostRdata = ctrlWord;
      HOST_AW'(OFF_LDATA): hostRdata = ldata;
      HOST_AW'(OFF_UDATA): hostRdata = udata;
      HOST_AW'(OFF_EN):    hostRdata = {30'd0, irqEn};
      HOST_AW'(OFF_FLAG):  hostRdata = {30'd0, irqFlag};
      default:             hostRdata = '0;
    endcase
  end

  assign irqOut   = |(irqFlag & irqEn);
  assign cfgLane0 = cfgBenL[0];
  assign subAddr  = cfgAddr;
  assign subWdata = ldata[7:0];
endmodule

// File: rtl/byte_reg_bridge.sv
module byte_reg_bridge
  import byte_bridge_pkg::*;
#(
  parameter int          HOST_AW  = 5,
  parameter int          SUB_AW   = 8,
  parameter logic [31:0] ID_VALUE = 32'h4252_0001
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostEn,
  input  logic               hostWe,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [31:0]        hostWdata,
  output logic [31:0]        hostRdata,
  output logic               subReq,
  output logic               subWr,
  output logic [SUB_AW-1:0]  subAddr,
  output logic [7:0]         subWdata,
  input  logic               subAck,
  input  logic [7:0]         subRdata,
  input  logic               subIrq,
  output logic               irqOut
);
  strobes_t stb;
  logic     busy;
  logic     cfgDir;
  logic     cfgLane0;

  byte_bridge_ctrl #(.HOST_AW(HOST_AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostEn(hostEn), .hostWe(hostWe),
    .hostAddr(hostAddr), .wrDir(hostWdata[BIT_DIR]),
    .wrLane0(hostWdata[LSB_BENL]), .wrFlagBits(hostWdata[1:0]),
    .cfgDir(cfgDir), .cfgLane0(cfgLane0), .subAck(subAck),
    .subIrq(subIrq), .stb(stb), .busy(busy)
  );

  byte_bridge_dp #(.HOST_AW(HOST_AW), .SUB_AW(SUB_AW), .ID_VALUE(ID_VALUE)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .subRdata(subRdata), .hostRdata(hostRdata),
    .irqOut(irqOut), .cfgDir(cfgDir), .cfgLane0(cfgLane0),
    .subAddr(subAddr), .subWdata(subWdata)
  );

  assign subReq = busy;
  assign subWr  = !cfgDir;
endmodule

// File: rtl/byte_reg_bridge_checker.sv
module byte_reg_bridge_checker
  import byte_bridge_pkg::*;
#(
  parameter int          HOST_AW  = 5,
  parameter int          SUB_AW   = 8,
  parameter logic [31:0] ID_VALUE = 32'h4252_0001
) (
  input logic               clk,
  input logic               rstN,
  input logic               hostEn,
  input logic               hostWe,
  input logic [HOST_AW-1:0] hostAddr,
  input logic [31:0]        hostWdata,
  input logic [31:0]        hostRdata,
  input logic               subReq,
  input logic               subWr,
  input logic [SUB_AW-1:0]  subAddr,
  input logic [7:0]         subWdata,
  input logic               subAck,
  input logic               irqOut
);
  assert_req_held_R5: assert property (@(posedge clk) disable iff (!rstN)
    (subReq && !subAck) |=> subReq);

  assert_req_drop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (subReq && subAck) |=> !subReq);

  assert_req_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (subReq && !subAck) |=> ($stable(subAddr) && $stable(subWdata) && $stable(subWr)));

  assert_irq_masked_R12: assert property (@(posedge clk) disable iff (!rstN)
    (hostEn && hostWe && hostAddr == HOST_AW'(OFF_EN) && hostWdata[1:0] == 2'b00) |=> !irqOut);

  assert_id_const_R2: assert property (@(posedge clk) disable iff (!rstN)
    (hostAddr == HOST_AW'(OFF_ID)) |-> (hostRdata == ID_VALUE));
endmodule

bind byte_reg_bridge byte_reg_bridge_checker #(
  .HOST_AW(HOST_AW), .SUB_AW(SUB_AW), .ID_VALUE(ID_VALUE)
) u_chk (
  .clk(clk), .rstN(rstN), .hostEn(hostEn), .hostWe(hostWe),
  .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
  .subReq(subReq), .subWr(subWr), .subAddr(subAddr), .subWdata(subWdata),
  .subAck(subAck), .irqOut(irqOut)
);

// File: tb/byte_reg_bridge_bench.sv
`timescale 1ns/1ps
module byte_reg_bridge_bench;
  localparam int HOST_AW = 5;
  localparam int SUB_AW  = 8;
  localparam int LAT     = 4;
  localparam logic [31:0] IDV = 32'h4252_0001;
  localparam logic [4:0] A_ID = 5'h00, A_CTRL = 5'h04, A_LD = 5'h08,
                         A_UD = 5'h0C, A_EN = 5'h10, A_FLAG = 5'h14;
  localparam logic [31:0] RD = 32'h0101_0000;  // dir=1, lane0
  localparam logic [31:0] WRC = 32'h0001_0000; // dir=0, lane0

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostEn = 1'b0, hostWe = 1'b0;
  logic [HOST_AW-1:0] hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic subReq, subWr, irqOut;
  logic [SUB_AW-1:0] subAddr;
  logic [7:0] subWdata;
  logic subAck;
  logic [7:0] subRdata;
  logic subIrq = 1'b0;

  int errors = 0;
  int checks = 0;
  int reqCount = 0;
  logic reqPrev;

  always #10 clk = ~clk;

  byte_reg_bridge u_byte_reg_bridge (
    .clk(clk), .rstN(rstN), .hostEn(hostEn), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .subReq(subReq), .subWr(subWr), .subAddr(subAddr), .subWdata(subWdata),
    .subAck(subAck), .subRdata(subRdata), .subIrq(subIrq), .irqOut(irqOut)
  );

  // subsystem model: byte memory answering after LAT request cycles
  logic [7:0] mem [256];
  int latCnt;
  always @(posedge clk) begin
    if (!rstN) begin
      subAck <= 1'b0; subRdata <= '0; latCnt <= 0; reqPrev <= 1'b0;
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i);
    end else begin
      reqPrev <= subReq;
      if (subReq && !reqPrev) reqCount <= reqCount + 1;
      subAck <= 1'b0;
      if (subReq && !subAck) begin
        if (latCnt == LAT) begin
          subAck <= 1'b1;
          latCnt <= 0;
          if (subWr) mem[subAddr] <= subWdata;
          else subRdata <= mem[subAddr];
        end else latCnt <= latCnt + 1;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic hostWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    hostEn = 1'b1; hostWe = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostEn = 1'b0; hostWe = 1'b0;
  endtask

  task automatic hostRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    hostEn = 1'b1; hostWe = 1'b0; hostAddr = a;
    #1 d = hostRdata;
    hostEn = 1'b0;
  endtask

  task automatic waitIdle(input string req);
    logic [31:0] v;
    bit idle = 0;
    for (int i = 0; i < 64; i++) begin
      hostRead(A_CTRL, v);
      if (!v[31]) begin idle = 1; break; end
    end
    check(req, 32'(idle), 32'd1);
  endtask

  task automatic testReset();
    logic [31:0] v;
    check("R1 subReq", 32'(subReq), 0);
    check("R1 irqOut", 32'(irqOut), 0);
    hostRead(A_CTRL, v); check("R1 ctrl", v, 0);
    hostRead(A_LD, v);   check("R1 ldata", v, 0);
    hostRead(A_UD, v);   check("R1 udata", v, 0);
    hostRead(A_EN, v);   check("R1 enable", v, 0);
    hostRead(A_FLAG, v); check("R1 flag", v, 0);
  endtask

  task automatic testId();
    logic [31:0] v;
    hostRead(A_ID, v); check("R2 id", v, IDV);
    hostWrite(A_ID, 32'hDEAD_BEEF);
    hostRead(A_ID, v); check("R2 id after write", v, IDV);
  endtask

  task automatic testWriteRead();
    logic [31:0] v;
    int c0 = reqCount;
    hostWrite(A_CTRL, WRC | 32'h3C);
    check("R4 no launch on ctrl", 32'(subReq), 0);
    hostRead(A_CTRL, v); check("R3 ctrl fields", v, WRC | 32'h3C);
    hostWrite(A_LD, 32'h1234_56A5);
    check("R4 launch", 32'(subReq), 1);
    check("R4 subWr", 32'(subWr), 1);
    waitIdle("R4 completes");
    check("R4 mem byte", 32'(mem[8'h3C]), 32'hA5);
    check("R5 req dropped", 32'(subReq), 0);
    hostWrite(A_CTRL, RD | 32'h3C);
    hostRead(A_CTRL, v); check("R3 busy set", 32'(v[31]), 1);
    check("R3 subWr read", 32'(subWr), 0);
    waitIdle("R3 completes");
    hostRead(A_LD, v); check("R3 zero-extended", v, 32'h0000_00A5);
    check("R4/R3 two requests", 32'(reqCount - c0), 2);
  endtask

  task automatic testBusyIgnore();
    logic [31:0] v;
    int c0 = reqCount;
    hostWrite(A_CTRL, RD | 32'h10);
    hostWrite(A_CTRL, WRC | 32'h22);
    hostWrite(A_LD, 32'h0000_00FF);
    waitIdle("R6 completes");
    hostRead(A_CTRL, v); check("R6 ctrl kept", v, RD | 32'h10);
    hostRead(A_LD, v);   check("R6 ldata is read byte", v, 32'h10);
    check("R6 one request", 32'(reqCount - c0), 1);
    check("R6 mem untouched", 32'(mem[8'h22]), 32'h22);
  endtask

  task automatic testLane0();
    logic [31:0] v;
    int c0 = reqCount;
    hostWrite(A_CTRL, 32'h0100_0030);
    hostRead(A_CTRL, v); check("R7 no busy on read", 32'(v[31]), 0);
    hostWrite(A_CTRL, 32'h0000_0031);
    hostWrite(A_LD, 32'h77);
    repeat (LAT + 3) @(negedge clk);
    check("R7 no request", 32'(reqCount - c0), 0);
    check("R7 mem untouched", 32'(mem[8'h31]), 32'h31);
  endtask

  task automatic testUpper();
    logic [31:0] v;
    int c0 = reqCount;
    hostWrite(A_CTRL, WRC | 32'h40);
    hostWrite(A_UD, 32'hCAFE_F00D);
    repeat (LAT + 3) @(negedge clk);
    hostRead(A_UD, v); check("R8 readback", v, 32'hCAFE_F00D);
    check("R8 no request", 32'(reqCount - c0), 0);
  endtask

  task automatic testFlags();
    logic [31:0] v;
    hostWrite(A_FLAG, 32'h3);
    hostRead(A_FLAG, v); check("R11 cleared", v, 0);
    hostWrite(A_CTRL, RD | 32'h05);
    waitIdle("R10 completes");
    hostRead(A_FLAG, v); check("R10 done flag", v, 32'h1);
    hostWrite(A_FLAG, 32'h0);
    hostRead(A_FLAG, v); check("R11 write 0 keeps", v, 32'h1);
    check("R12 masked", 32'(irqOut), 0);
    hostWrite(A_EN, 32'h2);
    check("R12 other source only", 32'(irqOut), 0);
    hostWrite(A_EN, 32'h1);
    check("R12 done enabled", 32'(irqOut), 1);
    hostWrite(A_FLAG, 32'h1);
    check("R12 after clear", 32'(irqOut), 0);
  endtask

  task automatic testIrqEdge();
    logic [31:0] v;
    hostWrite(A_EN, 32'h2);
    @(negedge clk) subIrq = 1'b1;
    repeat (2) @(negedge clk);
    hostRead(A_FLAG, v); check("R9 rise sets", v, 32'h2);
    check("R12 subsystem irq", 32'(irqOut), 1);
    hostWrite(A_FLAG, 32'h2);
    repeat (3) @(negedge clk);
    hostRead(A_FLAG, v); check("R9 level no reset", v, 0);
    check("R12 cleared", 32'(irqOut), 0);
    @(negedge clk) subIrq = 1'b0;
    @(negedge clk) subIrq = 1'b1;
    repeat (2) @(negedge clk);
    hostRead(A_FLAG, v); check("R9 second rise", v, 32'h2);
    @(negedge clk) subIrq = 1'b0;
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testId();
    testWriteRead();
    testBusyIgnore();
    testLane0();
    testUpper();
    testFlags();
    testIrqEdge();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule